// File: doc/BRIEF.md
# Per-CPU Interprocessor Mailbox Array

This block is a bank of sixteen 32-bit mailbox registers shared by a four-core cluster. Each core owns four mailboxes. The cores use them to signal one another and to hand a start address to a secondary core at boot. Software reaches the bank through a single-cycle register port with one byte address, a write enable with write data, and a read enable with read data.

A mailbox never takes a plain overwrite. A write to the set window ORs its data into the mailbox. A write to the clear window removes the bits written as one. Each core has one interrupt line. The line stays high as a level for as long as any bit is set in any of that core's four mailboxes. The fourth mailbox of each core also serves as the boot handoff register: a parked core polls it until a nonzero start address appears.

Top module: `mbx_array`

## Requirements
- R1: A synchronous reset clears all sixteen mailboxes to zero and drives all four interrupt outputs low. Writes presented while reset is high have no effect.
- R2: A write to the set window (byte addresses 0x80 to 0xBF) ORs `wr_data` into the addressed mailbox. Bits written as zero keep their value.
- R3: A write to the clear window (byte addresses 0xC0 to 0xFF) clears each bit of the addressed mailbox whose `wr_data` bit is one. All other bits keep their value.
- R4: In both windows, mailbox n of CPU c sits at the window base plus 16*c + 4*n, and address bits [1:0] are not decoded. For example, mailbox 3 of CPU 0 is at 0x8C for set and 0xCC for clear, and it holds a full 32-bit value such as a start address.
- R5: When `rd_en` is high and the address falls in either window, `rd_data` shows the addressed mailbox in the same cycle. If a write occurs in that cycle, `rd_data` shows the contents from before the write.
- R6: A write to an address below 0x80 changes no mailbox. A read of such an address returns zero, and `rd_data` is zero whenever `rd_en` is low.
- R7: `irq[c]` is a register holding the OR of CPU c's four mailbox nonzero flags. It therefore changes one clock after the mailbox state changes, which is at the second rising edge after the write cycle.
- R8: `irq[c]` stays high while any bit remains in CPU c's mailboxes. It falls only after the last set bit of that CPU has been cleared, so a partial clear leaves it high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Byte address for the read and the write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data (bits to set or to clear) |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Addressed mailbox contents, or zero |
| irq | output | 4 | Per-CPU level interrupt, bit c for CPU c |

## Verification
The hardest situation to reach is an interrupt that has to stay high through a partial clear. The bits of a CPU's mailboxes must be removed one at a time, and the line may fall only after the last one is gone. Uniform random data nearly always clears everything at once or leaves many bits behind. For that reason the random clear data is made sparse by ANDing several random words, and a directed sequence sets two bits and then removes them one at a time while the interrupt is tracked. The random run also mixes set and clear writes to the same few mailboxes, so that a mailbox empties and refills again and again across all four CPUs.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;
    localparam int NUM_CPU     = 4;
    localparam int MBX_PER_CPU = 4;
    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 8;
    localparam int SET_BASE    = 'h80;
    localparam int CLR_BASE    = 'hC0;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_SET  = 2'd1,
        ACC_CLR  = 2'd2
    } acc_kind_e;
endpackage

// File: rtl/mbx_decode.sv
`timescale 1ns/1ps
module mbx_decode
    import mbx_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int NUM_MBX  = 16,
    parameter int SET_BASE = 'h80,
    parameter int CLR_BASE = 'hC0,
    localparam int IDX_W   = $clog2(NUM_MBX)
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind,
    output logic [IDX_W-1:0]  idx
);
    localparam int SPAN = NUM_MBX * 4;

    always_comb begin
        int a;
        a    = int'(addr);
        kind = ACC_NONE;
        idx  = '0;
        if (a >= SET_BASE && a < SET_BASE + SPAN) begin
            kind = ACC_SET;
            idx  = IDX_W'((a - SET_BASE) / 4);
        end else if (a >= CLR_BASE && a < CLR_BASE + SPAN) begin
            kind = ACC_CLR;
            idx  = IDX_W'((a - CLR_BASE) / 4);
        end
    end
endmodule

// File: rtl/mbx_cell.sv
`timescale 1ns/1ps
module mbx_cell #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_en,
    input  logic              clr_en,
    input  logic [DATA_W-1:0] data,
    output logic [DATA_W-1:0] q
);
    logic [DATA_W-1:0] set_mask;
    logic [DATA_W-1:0] clr_mask;

    assign set_mask = set_en ? data : '0;
    assign clr_mask = clr_en ? data : '0;

    // Set applied after clear, so set wins on overlapping bits.
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q & ~clr_mask) | set_mask;
    end

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (q == '0));

    assert_set_bits_R2: assert property (@(posedge clk) disable iff (rst)
        set_en |=> ((q & $past(data)) == $past(data)));

    assert_clear_bits_R3: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !set_en) |=> ((q & $past(data)) == '0));

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!set_en && !clr_en) |=> $stable(q));
endmodule

// File: rtl/mbx_irq.sv
`timescale 1ns/1ps
module mbx_irq #(
    parameter int NUM_CPU     = 4,
    parameter int MBX_PER_CPU = 4,
    parameter int DATA_W      = 32,
    localparam int NUM_MBX    = NUM_CPU * MBX_PER_CPU
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] mbx [NUM_MBX],
    output logic [NUM_CPU-1:0] irq
);
    logic [NUM_CPU-1:0] nz;

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        always_comb begin
            nz[c] = 1'b0;
            for (int n = 0; n < MBX_PER_CPU; n++)
                nz[c] = nz[c] | (|mbx[c*MBX_PER_CPU + n]);
        end

        always_ff @(posedge clk) begin
            if (rst) irq[c] <= 1'b0;
            else     irq[c] <= nz[c];
        end

        assert_irq_fall_R8: assert property (@(posedge clk) disable iff (rst)
            $fell(irq[c]) |-> !$past(nz[c]));

        assert_irq_rise_R7: assert property (@(posedge clk) disable iff (rst)
            $rose(irq[c]) |-> $past(nz[c]));
    end
endmodule

// File: rtl/mbx_array.sv
`timescale 1ns/1ps
module mbx_array
    import mbx_pkg::*;
#(
    parameter int NUM_CPU     = mbx_pkg::NUM_CPU,
    parameter int MBX_PER_CPU = mbx_pkg::MBX_PER_CPU,
    parameter int DATA_W      = mbx_pkg::DATA_W,
    parameter int ADDR_W      = mbx_pkg::ADDR_W,
    parameter int SET_BASE    = mbx_pkg::SET_BASE,
    parameter int CLR_BASE    = mbx_pkg::CLR_BASE
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               rd_en,
    output logic [DATA_W-1:0]  rd_data,
    output logic [NUM_CPU-1:0] irq
);
    localparam int NUM_MBX = NUM_CPU * MBX_PER_CPU;
    localparam int IDX_W   = $clog2(NUM_MBX);
    localparam int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;
    localparam int SLOT_W  = $clog2(MBX_PER_CPU);

    acc_kind_e         kind;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] mbx [NUM_MBX];

    mbx_decode #(
        .ADDR_W  (ADDR_W),
        .NUM_MBX (NUM_MBX),
        .SET_BASE(SET_BASE),
        .CLR_BASE(CLR_BASE)
    ) u_decode (
        .addr(addr),
        .kind(kind),
        .idx (idx)
    );

    for (genvar i = 0; i < NUM_MBX; i++) begin : g_mbx
        logic hit;
        assign hit = wr_en && (idx == IDX_W'(i));
        mbx_cell #(.DATA_W(DATA_W)) u_cell (
            .clk   (clk),
            .rst   (rst),
            .set_en(hit && kind == ACC_SET),
            .clr_en(hit && kind == ACC_CLR),
            .data  (wr_data),
            .q     (mbx[i])
        );
    end

    mbx_irq #(
        .NUM_CPU    (NUM_CPU),
        .MBX_PER_CPU(MBX_PER_CPU),
        .DATA_W     (DATA_W)
    ) u_irq (
        .clk(clk),
        .rst(rst),
        .mbx(mbx),
        .irq(irq)
    );

    assign rd_data = (rd_en && kind != ACC_NONE) ? mbx[idx] : '0;

    // A nonzero set on a CPU's mailbox raises that CPU's line two edges on.
    logic [CPU_W-1:0] wr_cpu;
    assign wr_cpu = CPU_W'(idx >> SLOT_W);

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
        assert_set_raises_irq_R7: assert property (@(posedge clk) disable iff (rst)
            (wr_en && kind == ACC_SET && wr_data != '0 && wr_cpu == CPU_W'(c))
                |=> ##1 irq[c]);
    end

    assert_rd_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (!rd_en || kind == ACC_NONE) |-> (rd_data == '0));
endmodule

// File: tb/mbx_array_tb_top.sv
`timescale 1ns/1ps
module mbx_array_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  addr;
    logic        wr_en;
    logic [31:0] wr_data;
    logic        rd_en;
    logic [31:0] rd_data;
    logic [3:0]  irq;

    always #2 clk = ~clk;

    mbx_array dut_i (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq(irq)
    );

    int          errors = 0;
    int          checks = 0;
    bit          finished = 1'b0;
    logic [31:0] model [16];

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // -1 when the address lies outside both windows.
    function automatic int widx(logic [7:0] a);
        if (a[7]) return int'(a[5:2]);
        return -1;
    endfunction

    function automatic logic [3:0] model_irq();
        logic [3:0] r = '0;
        for (int c = 0; c < 4; c++)
            for (int n = 0; n < 4; n++)
                if (model[c*4+n] != 0) r[c] = 1'b1;
        return r;
    endfunction

    task automatic step(string tag, bit we, logic [7:0] a, logic [31:0] d, bit re);
        logic [31:0] exp_rd;
        logic [3:0]  exp_irq;
        int          k;
        @(negedge clk);
        wr_en = we; addr = a; wr_data = d; rd_en = re;
        #1;
        k = widx(a);
        exp_rd = (re && k >= 0) ? model[k] : 32'h0;
        chk(tag, rd_data, exp_rd);
        exp_irq = model_irq();
        if (we && k >= 0) begin
            if (a[6]) model[k] = model[k] & ~d;
            else      model[k] = model[k] | d;
        end
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R7 irq", {28'b0, irq}, {28'b0, exp_irq});
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        report();
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd20240611);
        for (int i = 0; i < 16; i++) model[i] = '0;
        rst = 1'b1; addr = 8'h84; wr_en = 1'b1; wr_data = 32'hFFFF_FFFF; rd_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0; wr_en = 1'b0;
        chk("R1 irq after reset", {28'b0, irq}, 32'h0);
        for (int i = 0; i < 16; i++) step("R1 mailbox zero", 0, 8'h80 + 8'(4*i), 0, 1);

        // R4: CPU0 mailbox 3 at 0x8C / 0xCC, low address bits ignored
        step("R4 write", 1, 8'h8C, 32'hDEAD_BEEF, 1);
        step("R4 clear-window read", 0, 8'hCC, 0, 1);
        step("R4 neighbour untouched", 0, 8'h80, 0, 1);
        step("R4 low bits ignored", 0, 8'h8F, 0, 1);
        step("R4 cpu2 slot1 write", 1, 8'hA4, 32'h0000_1000, 0);
        step("R4 cpu2 slot1 read", 0, 8'hE6, 0, 1);

        // R6: outside windows
        step("R6 out write", 1, 8'h44, 32'hFFFF_FFFF, 1);
        step("R6 out write", 1, 8'h7C, 32'hFFFF_FFFF, 1);
        for (int i = 0; i < 16; i++) step("R6 unchanged", 0, 8'h80 + 8'(4*i), 0, 1);
        step("R6 rd_en low", 0, 8'h8C, 0, 0);

        // R2 / R3 / R5
        step("R2 or-in", 1, 8'h8C, 32'h0000_00F0, 1);
        step("R2 result", 0, 8'h8C, 0, 1);
        step("R3 clear", 1, 8'hCC, 32'hFFFF_0000, 1);
        step("R3 result", 0, 8'hCC, 0, 1);
        step("R5 pre-write read", 1, 8'hCC, 32'hFFFF_FFFF, 1);
        step("R5 after clear", 0, 8'h8C, 0, 1);

        // R8: partial clear keeps CPU1 line up
        step("R8 set two bits", 1, 8'h90, 32'h3, 0);
        step("R8 clear one bit", 1, 8'hD0, 32'h1, 0);
        step("R8 remaining", 0, 8'h90, 0, 1);
        chk("R8 still high", {31'b0, irq[1]}, 32'h1);
        step("R8 clear last", 1, 8'hD0, 32'h2, 0);
        step("R8 idle", 0, 8'h00, 0, 0);
        chk("R8 dropped", {31'b0, irq[1]}, 32'h0);

        for (int i = 0; i < 16; i++) step("R3 wipe", 1, 8'hC0 + 8'(4*i), 32'hFFFF_FFFF, 0);

        // Random mix
        for (int s = 0; s < 3000; s++) begin
            int          op;
            logic [7:0]  a;
            logic [31:0] d;
            op = int'($urandom % 4);
            a  = {2'b10, 4'($urandom), 2'($urandom)};
            d  = $urandom & $urandom & $urandom;
            case (op)
                0: step("R2 random", 1, a, d, ($urandom % 4) != 0);
                1: step("R3 random", 1, {2'b11, a[5:0]}, d | ($urandom & $urandom), ($urandom % 4) != 0);
                2: step("R6 random", 1, {1'b0, 7'($urandom)}, $urandom, 1);
                default: step("R5 random", 0, {1'b1, 1'($urandom), a[5:0]}, 0, ($urandom % 4) != 0);
            endcase
        end
        report();
    end
endmodule